// File: doc/BRIEF.md
# RC6 infrared frame decoder

This block turns the output of an infrared receiver module into decoded RC6 frames. The receiver module has already removed the carrier, so the block sees one active-low line. The block runs on a 100 kHz sample clock. Its synchronous reset comes from power-on reset logic. The line first passes through a synchronizer and is then inverted, so that a logic 1 means the carrier is present (a mark). Next, an edge detector and a duration counter measure each constant level in samples. Each length is classed as one, two, three or six base units. One unit is 44 samples, about 444 µs.

A frame state machine checks the leader mark and leader space. It then walks through the Manchester-coded body: a start bit, three mode bits, a trailer bit whose halves last two units each, eight control bits and eight info bits. It records its place in the body in units. From each measured level it works out which bits' first halves that level covered. It collects those bits into a shift register and checks that every mid-bit transition happened.

When a frame is complete, the decoded fields go to the outputs and a one-cycle valid pulse is raised. When a frame breaks the timing rules, a one-cycle error pulse is raised instead and the decoder waits for the next leader.

Top module: `ir_frame_decoder`

## Requirements
- R1: After reset, `frameValid` and `frameError` are 0, and `mode`, `control` and `info` are all zero.
- R2: `irPinN` is active low: low is a mark and high is a space. The unit is `UNIT_SAMPLES` = 44 samples. A level is accepted as k units (k = 1, 2, 3, or 6 for the leader) when it lasts k·44 ± 11 samples.
- R3: A frame has the following parts, in order:
  - a 6-unit mark, then a 2-unit space;
  - a start bit of 1;
  - 3 mode bits;
  - a trailer bit whose halves last 2 units each;
  - 8 control bits, then 8 info bits.

  Every other bit lasts 2 units, and its value is 1 when its first half is a mark. Fields are shifted in MSB first and appear on `mode`, `control` and `info`.
- R4: At the end of a good frame, `frameValid` is high for exactly one cycle, and the new field values appear in that same cycle. The fields keep their values through idle periods and error frames until the next good frame.
- R5: A first mark whose length is outside the 6-unit window raises `frameError`.
- R6: A leader space whose length is not 2 units raises `frameError`. This includes a 3-unit space, which is how a start bit of 0 appears.
- R7: Inside the frame body, a level whose length is outside the 1, 2 and 3-unit windows raises `frameError`.
- R8: A level that spans a point where a mid-bit transition is required raises `frameError`. This includes the midpoint of the trailer bit.
- R9: While a frame is in progress, 8 units (352 samples) without an edge raise `frameError`. An idle line never raises an error.
- R10: `frameValid` and `frameError` are never high in the same cycle. After an error, the next well-formed frame decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 kHz sample clock |
| rst | input | 1 | Synchronous reset, active high |
| irPinN | input | 1 | Demodulated IR line from the receiver module, active low |
| mode | output | 3 | Decoded mode field |
| control | output | 8 | Decoded control field |
| info | output | 8 | Decoded info field |
| frameValid | output | 1 | One-cycle pulse when a frame has been received completely and correctly |
| frameError | output | 1 | One-cycle pulse when the timing or structure of a frame is malformed |

## Verification
The assertions check the following on every cycle:
- the valid pulse lasts one cycle;
- the fields do not change outside a valid pulse;
- valid and error are never raised together;
- the duration counter stays within its saturation limit;
- the frame position stays inside the body;
- a timeout in a busy state returns the decoder to idle and raises an error.

Only the bench scenarios can show the rest:
- that the fields are decoded correctly, including bit order, trailer polarity and edge jitter at the edge of the tolerance windows;
- that each kind of malformed frame raises exactly one error;
- that the decoder recovers after an error.

// File: rtl/irdec_pkg.sv
package irdec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD_MARK,
    ST_LEAD_SPACE,
    ST_DATA
  } frameState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] shiftCnt;  // number of bits to shift in (0..2)
    logic       publish;   // load output fields from the next shift value
  } ctlStrobe_t;
endpackage

// File: rtl/irdec_datapath.sv
module irdec_datapath
  import irdec_pkg::*;
#(
  parameter int UNIT_SAMPLES = 44,
  parameter int MODE_W       = 3,
  parameter int FIELD_W      = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irPinN,
  input  ctlStrobe_t         strobe,
  output logic               edgeSeen,
  output logic               markNow,
  output logic [2:0]         durUnits,
  output logic               timedOut,
  output logic [MODE_W-1:0]  modeQ,
  output logic [FIELD_W-1:0] ctlQ,
  output logic [FIELD_W-1:0] infoQ,
  output logic               validQ
);
  localparam int TOL     = UNIT_SAMPLES / 4;
  localparam int TIMEOUT = 8 * UNIT_SAMPLES;
  localparam int CNT_W   = $clog2(TIMEOUT + 1);
  localparam int SHIFT_W = MODE_W + 2 * FIELD_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   markPrev;
  logic [CNT_W-1:0]       cntQ;
  logic [SHIFT_W-1:0]     shiftQ, shiftNext;
  int                     dur;

  // synchronizer, idle line is high
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], irPinN};
  end

  assign markNow  = ~syncQ[SYNC_STAGES-1];
  assign edgeSeen = markNow ^ markPrev;

  always_ff @(posedge clk) begin
    if (rst) markPrev <= 1'b0;
    else     markPrev <= markNow;
  end

  // duration counter, saturating at the timeout
  always_ff @(posedge clk) begin
    if (rst)                          cntQ <= '0;
    else if (edgeSeen)                cntQ <= '0;
    else if (cntQ != CNT_W'(TIMEOUT)) cntQ <= cntQ + 1'b1;
  end

  assign timedOut = !edgeSeen && (cntQ == CNT_W'(TIMEOUT - 1));
  assign dur      = int'(cntQ) + 1;

  function automatic logic inWin(input int d, input int k);
    return (d >= k * UNIT_SAMPLES - TOL) && (d <= k * UNIT_SAMPLES + TOL);
  endfunction

  always_comb begin
    durUnits = 3'd0;
    if      (inWin(dur, 1)) durUnits = 3'd1;
    else if (inWin(dur, 2)) durUnits = 3'd2;
    else if (inWin(dur, 3)) durUnits = 3'd3;
    else if (inWin(dur, 6)) durUnits = 3'd6;
  end

  // deserializer: the level that just ended is markPrev
  always_comb begin
    case (strobe.shiftCnt)
      2'd1:    shiftNext = {shiftQ[SHIFT_W-2:0], markPrev};
      2'd2:    shiftNext = {shiftQ[SHIFT_W-3:0], markPrev, markPrev};
      default: shiftNext = shiftQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
      modeQ  <= '0;
      ctlQ   <= '0;
      infoQ  <= '0;
      validQ <= 1'b0;
    end else begin
      shiftQ <= shiftNext;
      validQ <= strobe.publish;
      if (strobe.publish) begin
        modeQ <= shiftNext[SHIFT_W-1 -: MODE_W];
        ctlQ  <= shiftNext[2*FIELD_W-1 -: FIELD_W];
        infoQ <= shiftNext[FIELD_W-1:0];
      end
    end
  end

  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    validQ |=> !validQ);
  a_r4_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !validQ |-> $stable({modeQ, ctlQ, infoQ}));
  a_r9_counter_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(cntQ) <= TIMEOUT);
endmodule

// File: rtl/irdec_control.sv
module irdec_control
  import irdec_pkg::*;
#(
  parameter int MODE_W  = 3,
  parameter int FIELD_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       edgeSeen,
  input  logic       markNow,
  input  logic [2:0] durUnits,
  input  logic       timedOut,
  output ctlStrobe_t strobe,
  output logic       frameErr
);
  // body positions in units, counted from the start bit
  localparam int MODE_START  = 2;
  localparam int TRAIL_START = MODE_START + 2 * MODE_W;
  localparam int CTL_START   = TRAIL_START + 4;
  localparam int LAST_UNIT   = CTL_START + 4 * FIELD_W - 1;
  localparam int POS_W       = $clog2(LAST_UNIT + 1);

  frameState_t      stateQ, stateNext;
  logic [POS_W-1:0] posQ, posNext;
  logic             errNext;
  logic             bad, finish;
  int               n, caps;

  // unit u is the first half of a bit that is kept
  function automatic logic isCapture(input int u);
    if (u >= MODE_START && u < TRAIL_START) return (u % 2) == 0;
    if (u >= CTL_START && u < LAST_UNIT)   return (u % 2) == 0;
    return 1'b0;
  endfunction

  // a transition is required just before unit b
  function automatic logic mustToggle(input int b);
    if (b == TRAIL_START + 2)               return 1'b1;
    if (b < TRAIL_START)                    return (b % 2) == 1;
    if (b > CTL_START && b <= LAST_UNIT)    return (b % 2) == 1;
    return 1'b0;
  endfunction

  always_comb begin
    n    = int'(durUnits);
    bad  = !(n >= 1 && n <= 3);
    caps = 0;
    for (int k = 1; k < 3; k++)
      if (k < n && mustToggle(int'(posQ) + k)) bad = 1'b1;
    for (int k = 0; k < 3; k++)
      if (k < n && isCapture(int'(posQ) + k)) caps = caps + 1;
    finish = (int'(posQ) + n) >= LAST_UNIT;
  end

  always_comb begin
    stateNext = stateQ;
    posNext   = posQ;
    errNext   = 1'b0;
    strobe    = '0;
    case (stateQ)
      ST_IDLE:
        if (edgeSeen && markNow) stateNext = ST_LEAD_MARK;
      ST_LEAD_MARK:
        if (edgeSeen) begin
          if (durUnits == 3'd6) stateNext = ST_LEAD_SPACE;
          else begin errNext = 1'b1; stateNext = ST_IDLE; end
        end else if (timedOut) begin
          errNext = 1'b1; stateNext = ST_IDLE;
        end
      ST_LEAD_SPACE:
        if (edgeSeen) begin
          if (durUnits == 3'd2) begin stateNext = ST_DATA; posNext = '0; end
          else begin errNext = 1'b1; stateNext = ST_IDLE; end
        end else if (timedOut) begin
          errNext = 1'b1; stateNext = ST_IDLE;
        end
      ST_DATA:
        if (edgeSeen) begin
          if (bad) begin
            errNext = 1'b1; stateNext = ST_IDLE;
          end else begin
            strobe.shiftCnt = 2'(caps);
            if (finish) begin
              strobe.publish = 1'b1;
              stateNext      = ST_IDLE;
            end else begin
              posNext = POS_W'(int'(posQ) + n);
            end
          end
        end else if (timedOut) begin
          errNext = 1'b1; stateNext = ST_IDLE;
        end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_IDLE;
      posQ     <= '0;
      frameErr <= 1'b0;
    end else begin
      stateQ   <= stateNext;
      posQ     <= posNext;
      frameErr <= errNext;
    end
  end

  a_r3_pos_inside_body: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_DATA) |-> (int'(posQ) < LAST_UNIT));
  a_r9_timeout_to_idle: assert property (@(posedge clk) disable iff (rst)
    (stateQ != ST_IDLE && timedOut) |=> (stateQ == ST_IDLE && frameErr));
endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder
  import irdec_pkg::*;
#(
  parameter int UNIT_SAMPLES = 44,
  parameter int MODE_W       = 3,
  parameter int FIELD_W      = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irPinN,
  output logic [MODE_W-1:0]  mode,
  output logic [FIELD_W-1:0] control,
  output logic [FIELD_W-1:0] info,
  output logic               frameValid,
  output logic               frameError
);
  ctlStrobe_t strobe;
  logic       edgeSeen, markNow, timedOut;
  logic [2:0] durUnits;

  irdec_datapath #(
    .UNIT_SAMPLES(UNIT_SAMPLES), .MODE_W(MODE_W),
    .FIELD_W(FIELD_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .irPinN(irPinN), .strobe(strobe),
    .edgeSeen(edgeSeen), .markNow(markNow), .durUnits(durUnits),
    .timedOut(timedOut), .modeQ(mode), .ctlQ(control), .infoQ(info),
    .validQ(frameValid)
  );

  irdec_control #(.MODE_W(MODE_W), .FIELD_W(FIELD_W)) u_ctl (
    .clk(clk), .rst(rst), .edgeSeen(edgeSeen), .markNow(markNow),
    .durUnits(durUnits), .timedOut(timedOut), .strobe(strobe),
    .frameErr(frameError)
  );

  a_r10_valid_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(frameValid && frameError));
endmodule

// File: tb/tb_ir_frame_decoder.sv
`timescale 1ns/1ps
module tb_ir_frame_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int U          = 44;
  localparam int GAP        = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irPinN = 1'b1;
  logic [2:0] mode;
  logic [7:0] control, info;
  logic       frameValid, frameError;

  ir_frame_decoder dut (
    .clk(clk), .rst(rst), .irPinN(irPinN), .mode(mode), .control(control),
    .info(info), .frameValid(frameValid), .frameError(frameError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit         isErr;
    logic [2:0] m;
    logic [7:0] c;
    logic [7:0] i;
    string      tag;
  } item_t;

  item_t      expQ[$];
  int         nChecks = 0, nFails = 0;
  logic [2:0] heldM = '0;
  logic [7:0] heldC = '0, heldI = '0;
  bit         done = 0;
  bit         prevValid = 0;

  task automatic drive(input bit mark, input int samples);
    irPinN = ~mark;
    repeat (samples) @(negedge clk);
  endtask

  task automatic expectGood(input [2:0] m, input [7:0] c, input [7:0] i, input string tag);
    item_t it;
    it.isErr = 0; it.m = m; it.c = c; it.i = i; it.tag = tag;
    expQ.push_back(it);
    heldM = m; heldC = c; heldI = i;
  endtask

  task automatic expectErr(input string tag);
    item_t it;
    it.isErr = 1; it.m = heldM; it.c = heldC; it.i = heldI; it.tag = tag;
    expQ.push_back(it);
  endtask

  // builds leader + body as units, then drives run lengths with alternating jitter
  task automatic sendFrame(input [2:0] m, input [7:0] c, input [7:0] i,
                           input bit trl, input int jit, input string tag);
    bit u[52];
    int idx;
    int seg;
    expectGood(m, c, i, tag);
    for (int k = 0; k < 6; k++) u[k] = 1;
    u[6] = 0; u[7] = 0;
    u[8] = 1; u[9] = 0;
    for (int b = 0; b < 3; b++) begin
      u[10 + 2*b] = m[2-b]; u[11 + 2*b] = ~m[2-b];
    end
    u[16] = trl; u[17] = trl; u[18] = ~trl; u[19] = ~trl;
    for (int b = 0; b < 8; b++) begin
      u[20 + 2*b] = c[7-b]; u[21 + 2*b] = ~c[7-b];
      u[36 + 2*b] = i[7-b]; u[37 + 2*b] = ~i[7-b];
    end
    idx = 0; seg = 0;
    while (idx < 52) begin
      bit lv;
      int run;
      lv = u[idx]; run = 0;
      while (idx < 52 && u[idx] == lv) begin run++; idx++; end
      drive(lv, run * U + (((seg % 2) == 0) ? jit : -jit));
      seg++;
    end
    drive(0, GAP);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (prevValid && frameValid) begin
        nChecks++; nFails++;
        $display("FAIL R4: valid high two cycles, actual=1 expected=0");
      end
      prevValid = frameValid;
      if (frameValid || frameError) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL R9/R10: unexpected event valid=%0b err=%0b, expected none",
                   frameValid, frameError);
        end else begin
          item_t e;
          e = expQ.pop_front();
          if (frameError !== e.isErr || frameValid !== !e.isErr ||
              mode !== e.m || control !== e.c || info !== e.i) begin
            nFails++;
            $display("FAIL %s: actual err=%0b m=%0h c=%0h i=%0h expected err=%0b m=%0h c=%0h i=%0h",
                     e.tag, frameError, mode, control, info, e.isErr, e.m, e.c, e.i);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    nChecks++;
    if (frameValid !== 0 || frameError !== 0 || mode !== 0 || control !== 0 || info !== 0) begin
      nFails++;
      $display("FAIL R1: reset outputs actual v=%0b e=%0b m=%0h c=%0h i=%0h expected all 0",
               frameValid, frameError, mode, control, info);
    end
    drive(0, GAP);

    // R3 good frames, R2 jitter at window edges
    sendFrame(3'b101, 8'hA5, 8'h3C, 1, 0,   "R3 mixed");
    sendFrame(3'b000, 8'h00, 8'h00, 0, 0,   "R3 all zero");
    sendFrame(3'b111, 8'hFF, 8'hFF, 1, 0,   "R3 all ones");
    sendFrame(3'b010, 8'h5A, 8'hC3, 0, 11,  "R2 jitter +");
    sendFrame(3'b110, 8'h81, 8'h7E, 1, -11, "R2 jitter -");

    // R5 leader mark too short
    expectErr("R5 short leader"); drive(1, 4*U); drive(0, GAP);
    // R6 start bit zero (3-unit leader space)
    expectErr("R6 start zero");
    drive(1, 6*U); drive(0, 3*U); drive(1, U); drive(0, GAP);
    // R7 body level outside windows
    expectErr("R7 out of window");
    drive(1, 6*U); drive(0, 2*U); drive(1, 66); drive(0, GAP);
    // R8 missing mid-bit transition in a mode bit
    expectErr("R8 mode mid");
    drive(1, 6*U); drive(0, 2*U); drive(1, U); drive(0, U); drive(1, 2*U); drive(0, GAP);
    // R8 missing trailer midpoint transition
    expectErr("R8 trailer mid");
    drive(1, 6*U); drive(0, 2*U);
    drive(1, U); drive(0, 2*U); drive(1, U); drive(0, U); drive(1, 2*U); drive(0, U);
    drive(1, 3*U); drive(0, GAP);
    // R9 timeout in body
    expectErr("R9 timeout");
    drive(1, 6*U); drive(0, 2*U); drive(1, U); drive(0, 500); drive(0, GAP);

    // R10 recovery after errors
    sendFrame(3'b001, 8'h0F, 8'hF0, 0, 0, "R10 recovery");
    drive(0, 2*GAP);

    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R10: %0d expected events missing, expected 0", expQ.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule